// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block decides from the receive side of a twisted-pair Ethernet port whether the link is up. Its inputs are a receive-activity level, a one-cycle strobe for each detected link pulse, a transmit-activity level and a test-enable input. A one-millisecond tick drives three timers: a loss window, a minimum spacing between pulses and a maximum spacing between pulses. The outputs are a link-good flag and enables for the transmitter, the receiver and the loopback path.

When no receive data and no properly spaced link pulse arrives within the loss window, the monitor enters a failed condition. Pulses that come too close to the last accepted one are discarded. The monitor leaves the failed condition when a data packet arrives or when it has counted enough well-spaced pulses. It then passes through an extended-fail state, in which only the transmitter stays blocked, until both the receive and transmit paths are quiet. All timer limits and the pulse target are parameters, so a bench can shrink them.

Top module: `link_integrity_mon`

## Requirements
- R1: While `test_en` is low, all four outputs are 1 whatever the other inputs do. When `test_en` rises again, monitoring restarts with a fresh loss window.
- R2: In the monitoring state with `test_en` high, `LOSS_MS` consecutive ticks with no receive activity and no accepted pulse leave all outputs at 1. The next clock edge moves the block to the fail-reset state.
- R3: In the monitoring state, receive activity or an accepted link pulse restarts the loss window from zero ticks.
- R4: A link pulse that arrives before `MIN_MS` ticks have passed since the last accepted pulse, or since the block last entered the monitoring state, is ignored. It does not count toward recovery and does not restart any timer.
- R5: A synchronous active-high reset puts the block into the monitoring state with all outputs at 1 and all timers cleared.
- R6: In the fail-reset, pulse-wait and main fail states, all four outputs are 0.
- R7: In the fail states, each accepted pulse adds one to a pulse counter. Reaching `PULSE_MAX` moves the block to extended-fail. A lower count returns it to the main fail state.
- R8: Receive activity while in fail-reset, pulse-wait or main fail moves the block to extended-fail.
- R9: In extended-fail, `link_good` and `tx_en` are 0 and `rx_en` and `lpbk_en` are 1. The block returns to monitoring on the first cycle in which both `rx_act` and `tx_act` are low.
- R10: In the main fail state, `MAX_MS` ticks with no receive activity and no accepted pulse send the block back to fail-reset. That transition clears the pulse counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle strobe each millisecond |
| test_en | input | 1 | 1 runs the link test, 0 bypasses it (link always good) |
| rx_act | input | 1 | Receive data activity present |
| tx_act | input | 1 | Transmit data activity present |
| lp_strobe | input | 1 | One-cycle strobe per detected link pulse |
| link_good | output | 1 | Link reported up |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| lpbk_en | output | 1 | Loopback path enable |

## Verification
The hardest cases to reach from the ports are the ones where the main fail state loses its pulse count through a maximum-interval timeout, and where a pulse is rejected as too early. Neither changes any output directly. The stimulus first walks the block into main fail with a count of one and lets the maximum timer expire. It then sends one more spaced pulse: if the count was cleared the block stays in fail, and if the count survived or the timeout did nothing the block jumps to extended-fail. Early pulses are placed a known number of ticks after an accepted one, so that wrongly accepting one completes the pulse target and shows up as a premature extended-fail.

// File: rtl/lim_pkg.sv
package lim_pkg;

   typedef enum logic [2:0] {
      LS_MON  = 3'd0,   // monitoring, link up
      LS_RST  = 3'd1,   // fail, counter cleared
      LS_WAIT = 3'd2,   // fail, pulse just counted
      LS_FAIL = 3'd3,   // fail, waiting for spaced pulses
      LS_EXT  = 3'd4    // recovered, waiting for quiet paths
   } lim_state_e;

endpackage

// File: rtl/lim_ms_timer.sv
module lim_ms_timer #(
   parameter int LIMIT_MS = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   input  logic tick,
   output logic done
);

   localparam int CW = (LIMIT_MS < 2) ? 1 : $clog2(LIMIT_MS + 1);

   generate
      if (LIMIT_MS == 1) begin : g_flag
         logic seen;
         always_ff @(posedge clk) begin
            if (rst || restart) seen <= 1'b0;
            else if (tick)      seen <= 1'b1;
         end
         assign done = seen;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst || restart)                 cnt <= '0;
            else if (tick && cnt != CW'(LIMIT_MS)) cnt <= cnt + 1'b1;
         end
         assign done = (cnt == CW'(LIMIT_MS));
      end
   endgenerate

   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (done && !restart) |=> done);   // R2

endmodule

// File: rtl/lim_fsm.sv
module lim_fsm
   import lim_pkg::*;
#(
   parameter int PULSE_MAX = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       test_en,
   input  logic       rx_act,
   input  logic       tx_act,
   input  logic       lp_strobe,
   input  logic       loss_done,
   input  logic       min_done,
   input  logic       max_done,
   output logic       loss_restart,
   output logic       min_restart,
   output logic       max_restart,
   output lim_state_e state
);

   localparam int PW = $clog2(PULSE_MAX + 1);

   lim_state_e    nxt;
   logic [PW-1:0] pcnt;
   logic          valid_lp, cnt_clr, cnt_inc, at_target;

   assign valid_lp  = lp_strobe && min_done;
   assign at_target = (pcnt == PW'(PULSE_MAX));

   always_comb begin
      nxt     = state;
      cnt_clr = 1'b0;
      cnt_inc = 1'b0;
      if (!test_en) begin
         nxt     = LS_MON;
         cnt_clr = 1'b1;
      end else begin
         case (state)
            LS_MON: begin
               if (!(rx_act || valid_lp) && loss_done) begin
                  nxt     = LS_RST;
                  cnt_clr = 1'b1;
               end
            end
            LS_RST: begin
               if (rx_act)        nxt = LS_EXT;
               else if (valid_lp) begin nxt = LS_WAIT; cnt_inc = 1'b1; end
            end
            LS_WAIT: nxt = (rx_act || at_target) ? LS_EXT : LS_FAIL;
            LS_FAIL: begin
               if (rx_act)        nxt = LS_EXT;
               else if (valid_lp) begin nxt = LS_WAIT; cnt_inc = 1'b1; end
               else if (max_done) begin nxt = LS_RST; cnt_clr = 1'b1; end
            end
            LS_EXT:  if (!rx_act && !tx_act) nxt = LS_MON;
            default: nxt = LS_MON;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= LS_MON;
         pcnt  <= '0;
      end else begin
         state <= nxt;
         if (cnt_clr)                   pcnt <= '0;
         else if (cnt_inc && !at_target) pcnt <= pcnt + 1'b1;
      end
   end

   assign loss_restart = !test_en
                      || (state == LS_MON && (rx_act || valid_lp))
                      || (nxt == LS_MON && state != LS_MON);
   assign min_restart  = !test_en
                      || (valid_lp && (state == LS_MON || state == LS_RST || state == LS_FAIL))
                      || (nxt == LS_MON && state != LS_MON);
   assign max_restart  = (nxt == LS_FAIL) && (state != LS_FAIL);

   AST_BYPASS_TO_MON: assert property (@(posedge clk) disable iff (rst)
      !test_en |=> state == LS_MON);   // R1
   AST_LOSS_TO_RESET: assert property (@(posedge clk) disable iff (rst)
      (test_en && state == LS_MON && loss_done && !rx_act && !valid_lp) |=> state == LS_RST);   // R2
   AST_EARLY_PULSE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
      (test_en && state == LS_FAIL && lp_strobe && !min_done && !max_done && !rx_act) |=> $stable(pcnt));   // R4
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
      pcnt <= PW'(PULSE_MAX));   // R7
   AST_EXT_EXIT: assert property (@(posedge clk) disable iff (rst)
      (test_en && state == LS_EXT && !rx_act && !tx_act) |=> state == LS_MON);   // R9
   AST_MAX_TO_RESET: assert property (@(posedge clk) disable iff (rst)
      (test_en && state == LS_FAIL && max_done && !rx_act && !valid_lp) |=> state == LS_RST);   // R10
   AST_RESET_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
      state == LS_RST |-> pcnt == '0);   // R10

endmodule

// File: rtl/link_integrity_mon.sv
module link_integrity_mon
   import lim_pkg::*;
#(
   parameter int LOSS_MS   = 100,
   parameter int MIN_MS    = 4,
   parameter int MAX_MS    = 50,
   parameter int PULSE_MAX = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ms_tick,
   input  logic test_en,
   input  logic rx_act,
   input  logic tx_act,
   input  logic lp_strobe,
   output logic link_good,
   output logic tx_en,
   output logic rx_en,
   output logic lpbk_en
);

   generate
      if (LOSS_MS < 1 || MIN_MS < 1 || MAX_MS < 1)
         $error("timer limits must be at least one tick");
      if (MIN_MS >= MAX_MS || MIN_MS >= LOSS_MS)
         $error("minimum pulse spacing must be below the other windows");
      if (PULSE_MAX < 1)
         $error("pulse target must be at least one");
   endgenerate

   lim_state_e state;
   logic loss_done, min_done, max_done;
   logic loss_restart, min_restart, max_restart;

   lim_ms_timer #(.LIMIT_MS(LOSS_MS)) u_loss (
      .clk(clk), .rst(rst), .restart(loss_restart), .tick(ms_tick), .done(loss_done));
   lim_ms_timer #(.LIMIT_MS(MIN_MS)) u_min (
      .clk(clk), .rst(rst), .restart(min_restart), .tick(ms_tick), .done(min_done));
   lim_ms_timer #(.LIMIT_MS(MAX_MS)) u_max (
      .clk(clk), .rst(rst), .restart(max_restart), .tick(ms_tick), .done(max_done));

   lim_fsm #(.PULSE_MAX(PULSE_MAX)) u_fsm (
      .clk(clk), .rst(rst), .test_en(test_en), .rx_act(rx_act), .tx_act(tx_act),
      .lp_strobe(lp_strobe), .loss_done(loss_done), .min_done(min_done),
      .max_done(max_done), .loss_restart(loss_restart), .min_restart(min_restart),
      .max_restart(max_restart), .state(state));

   logic path_block;
   assign path_block = (state == LS_RST) || (state == LS_WAIT) || (state == LS_FAIL);

   assign link_good = !test_en || (state == LS_MON);
   assign tx_en     = !test_en || (state == LS_MON);
   assign rx_en     = !test_en || !path_block;
   assign lpbk_en   = !test_en || !path_block;

endmodule

// File: tb/tb_link_integrity_mon.sv
module tb_link_integrity_mon;

   localparam int CLK_PERIOD = 10;
   localparam int NROW = 15;

   logic clk = 1'b0;
   logic rst, ms_tick, test_en, rx_act, tx_act, lp_strobe;
   logic link_good, tx_en, rx_en, lpbk_en;
   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   link_integrity_mon #(.LOSS_MS(10), .MIN_MS(3), .MAX_MS(8), .PULSE_MAX(2)) dut (
      .clk(clk), .rst(rst), .ms_tick(ms_tick), .test_en(test_en), .rx_act(rx_act),
      .tx_act(tx_act), .lp_strobe(lp_strobe), .link_good(link_good), .tx_en(tx_en),
      .rx_en(rx_en), .lpbk_en(lpbk_en));

   // row: rep[19:12] tick rx tx lp [11:8] expected {good,tx,rx,lpbk} [7:4] req [3:0]
   localparam logic [19:0] VEC [NROW] = '{
      {8'd10, 4'b1000, 4'b1111, 4'd2},  // R2 window not yet over
      {8'd1,  4'b0000, 4'b0000, 4'd6},  // R6 fail-reset, all off
      {8'd1,  4'b0001, 4'b0000, 4'd6},  // R6 first pulse -> wait
      {8'd1,  4'b0000, 4'b0000, 4'd7},  // R7 count 1 -> main fail
      {8'd1,  4'b0001, 4'b0000, 4'd4},  // R4 pulse too soon
      {8'd3,  4'b1000, 4'b0000, 4'd4},  // R4 spacing elapses
      {8'd1,  4'b0001, 4'b0000, 4'd7},  // R7 second pulse -> wait
      {8'd1,  4'b0000, 4'b0011, 4'd7},  // R7 target reached -> extended
      {8'd1,  4'b0100, 4'b0011, 4'd9},  // R9 rx busy holds
      {8'd1,  4'b0010, 4'b0011, 4'd9},  // R9 tx busy holds
      {8'd1,  4'b0000, 4'b1111, 4'd9},  // R9 both quiet -> monitoring
      {8'd8,  4'b1000, 4'b1111, 4'd3},  // R3 part of window
      {8'd1,  4'b0001, 4'b1111, 4'd3},  // R3 pulse restarts window
      {8'd10, 4'b1000, 4'b1111, 4'd3},  // R3 full new window
      {8'd1,  4'b0000, 4'b0000, 4'd2}   // R2 expiry -> fail
   };

   task automatic step(input logic t, input logic r, input logic x, input logic p);
      ms_tick = t; rx_act = r; tx_act = x; lp_strobe = p;
      @(posedge clk);
      #1;
      ms_tick = 1'b0; rx_act = 1'b0; tx_act = 1'b0; lp_strobe = 1'b0;
   endtask

   task automatic chk(input logic [3:0] exp, input string req);
      logic [3:0] act;
      act = {link_good, tx_en, rx_en, lpbk_en};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s outputs=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic ticks(input int n, input logic [3:0] exp, input string req);
      for (int i = 0; i < n; i++) begin
         step(1'b1, 1'b0, 1'b0, 1'b0);
         chk(exp, req);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; test_en = 1'b1;
      ms_tick = 1'b0; rx_act = 1'b0; tx_act = 1'b0; lp_strobe = 1'b0;
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);
      rst = 1'b0;
      chk(4'b1111, "R5 after reset");

      for (int row = 0; row < NROW; row++) begin
         for (int k = 0; k < int'(VEC[row][19:12]); k++) begin
            step(VEC[row][11], VEC[row][10], VEC[row][9], VEC[row][8]);
            chk(VEC[row][7:4], $sformatf("R%0d table row %0d", VEC[row][3:0], row));
         end
      end

      // R10: timeout in main fail clears the count (now in fail-reset)
      step(0, 0, 0, 1); chk(4'b0000, "R10 pulse to wait");
      step(0, 0, 0, 0); chk(4'b0000, "R10 into main fail");
      ticks(8, 4'b0000, "R10 max window");
      step(0, 0, 0, 0); chk(4'b0000, "R10 back to fail-reset");
      step(0, 0, 0, 1); chk(4'b0000, "R10 pulse after timeout");
      step(0, 0, 0, 0); chk(4'b0000, "R10 count restarted, stays in fail");

      // R8: data packet recovers from fail-reset
      ticks(8, 4'b0000, "R10 second max window");
      step(0, 0, 0, 0); chk(4'b0000, "R10 fail-reset again");
      step(0, 1, 0, 0); chk(4'b0011, "R8 rx activity -> extended");
      step(0, 0, 1, 0); chk(4'b0011, "R9 tx busy holds extended");
      step(0, 0, 0, 0); chk(4'b1111, "R9 quiet -> monitoring");

      // R3: receive activity restarts the loss window
      ticks(9, 4'b1111, "R3 before activity");
      step(0, 1, 0, 0); chk(4'b1111, "R3 activity");
      ticks(10, 4'b1111, "R3 new window");
      step(0, 0, 0, 0); chk(4'b0000, "R2 expiry after restart");

      // R1: bypass
      test_en = 1'b0;
      step(0, 0, 0, 0); chk(4'b1111, "R1 bypass immediate");
      ticks(20, 4'b1111, "R1 bypass long");
      test_en = 1'b1;
      step(0, 0, 0, 0); chk(4'b1111, "R1 re-enable fresh");
      ticks(10, 4'b1111, "R1 fresh window");
      step(0, 0, 0, 0); chk(4'b0000, "R2 expiry after re-enable");

      // R5: reset from a fail state
      rst = 1'b1;
      step(0, 0, 0, 0);
      rst = 1'b0;
      chk(4'b1111, "R5 reset from fail");
      ticks(10, 4'b1111, "R5 timers cleared");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule